// File: doc/BRIEF.md
# Channel Status Block Marker Serializer

This block sits behind a digital audio receiver that has already recovered the bit stream, removed the biphase coding and found the preambles. For every decoded subframe it is given a one-cycle strobe, the two-bit preamble class and the channel status, user and validity bits of that subframe. From these it builds three serial bit streams (C, U and V) that advance on every edge of the output port's left/right word clock, so one bit is presented per word-clock phase. It also drives a block-start marker that shows where each 192-frame channel status block begins.

A frame counter runs from one block-start preamble to the next. While it runs it checks that every block holds exactly 192 frames, and it raises a framing-error flag when a block starts early or late. Until the first block-start preamble has arrived there is no block alignment. The marker is then held low and an unsynced flag is high. The validity output can be switched from serial pacing to a static level that follows the validity bit of the latest subframe, so that a low level means valid linear PCM.

Top module: `csblk_serializer`

## Requirements
- R1: Once the block is synced, a subframe strobe with preamble class Z (`sf_pre` = 2'b00) drives `blk_mark` high from the clock after that strobe until the clock after the next strobe of any class. Class X is 2'b01, class Y is 2'b10 and 2'b11 is treated like Y.
- R2: While no Z strobe has been seen since reset, `unsynced` is 1 and `blk_mark` is 0, including during X and Y strobes. The first Z strobe clears `unsynced` on the next clock and does not raise `blk_mark`.
- R3: A Z or X strobe starts a new frame. After sync, a Z strobe that arrives with exactly 191 X strobes since the previous Z clears `frame_err`. A Z strobe at any other count sets `frame_err`, and the flag holds until the next on-time Z. The first Z never sets `frame_err`.
- R4: The C, U and V bits are latched on each strobe. On every rising and every falling transition of `lrck`, `c_ser`, `u_ser` and `v_ser` take the latched bits one clock after the transition is sampled.
- R5: While `lrck` does not change, `c_ser` and `u_ser` (and `v_ser` with `vmode` = 0) hold their values even when new subframes are latched.
- R6: With `vmode` = 1, `v_ser` equals the validity bit of the most recent strobe from the clock after that strobe, whatever `lrck` does. A low level means valid linear PCM.
- R7: A synchronous active-high `rst` sets `unsynced` to 1 and clears `blk_mark`, `frame_err`, the frame count and all serial outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sf_valid | input | 1 | One-cycle strobe per decoded subframe |
| sf_pre | input | 2 | Preamble class: 00 Z, 01 X, 10 Y |
| sf_c | input | 1 | Channel status bit of the subframe |
| sf_u | input | 1 | User bit of the subframe |
| sf_v | input | 1 | Validity bit of the subframe |
| lrck | input | 1 | Output port word clock, synchronous to clk |
| vmode | input | 1 | 0: serial validity, 1: static validity level |
| blk_mark | output | 1 | Block-start marker |
| unsynced | output | 1 | High until the first Z preamble |
| frame_err | output | 1 | Block length error flag |
| c_ser | output | 1 | Serial channel status bit |
| u_ser | output | 1 | Serial user bit |
| v_ser | output | 1 | Serial validity bit or validity level |

## Verification
The serializer is driven with a table of eight C/U/V combinations. These include all-zero, all-one and each single bit set alone, so a swapped or stuck lane shows up as a mismatch. The table alternates rising and falling word-clock transitions, which shows whether both edges advance the stream. The framer is fed X strobes before sync, then a block of exactly 192 frames, then one short block. This separates a marker that fires on the first Z, a counter that is off by one and an error flag that never clears or never sets. Separate runs hold the word clock still while new subframes arrive and switch the validity output to level mode, which tells pacing by the word clock apart from pacing by the strobe.

// File: rtl/csblk_pkg.sv
package csblk_pkg;

    localparam int FRAMES_PER_BLOCK = 192;
    localparam int LANES            = 3;
    localparam int LANE_C           = 0;
    localparam int LANE_U           = 1;
    localparam int LANE_V           = 2;

    typedef enum logic [1:0] {
        PRE_Z   = 2'b00,
        PRE_X   = 2'b01,
        PRE_Y   = 2'b10,
        PRE_RSV = 2'b11
    } pre_t;

    typedef struct packed {
        logic v;
        logic u;
        logic c;
    } aux_bits_t;

    function automatic logic opens_frame(pre_t p);
        return (p == PRE_Z) || (p == PRE_X);
    endfunction

    function automatic logic opens_block(pre_t p);
        return p == PRE_Z;
    endfunction

endpackage

// File: rtl/csblk_framer.sv
module csblk_framer
    import csblk_pkg::*;
#(
    parameter int FRAMES = FRAMES_PER_BLOCK,
    localparam int CNT_W = $clog2(FRAMES)
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  pre_t pre,
    output logic mark,
    output logic synced,
    output logic err
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAMES - 1);

    logic [CNT_W-1:0] cnt;
    logic             is_z;
    logic             is_x;

    always_comb begin
        is_z = strobe && opens_block(pre);
        is_x = strobe && opens_frame(pre) && !opens_block(pre);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            mark   <= 1'b0;
            synced <= 1'b0;
            err    <= 1'b0;
        end else if (is_z) begin
            cnt    <= '0;
            mark   <= synced;
            synced <= 1'b1;
            if (synced) begin
                err <= (cnt != LAST);
            end
        end else if (strobe) begin
            mark <= 1'b0;
            if (is_x && synced) begin
                cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/csblk_shifter.sv
module csblk_shifter
    import csblk_pkg::*;
#(
    parameter int NLANE = LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic [NLANE-1:0] bits_in,
    input  logic             lrck,
    output logic [NLANE-1:0] held,
    output logic [NLANE-1:0] ser
);

    logic lrck_q;
    logic phase_edge;

    always_comb phase_edge = (lrck != lrck_q);

    always_ff @(posedge clk) begin
        if (rst) lrck_q <= 1'b0;
        else     lrck_q <= lrck;
    end

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                held[l] <= 1'b0;
                ser[l]  <= 1'b0;
            end else begin
                if (strobe)     held[l] <= bits_in[l];
                if (phase_edge) ser[l]  <= held[l];
            end
        end
    end

endmodule

// File: rtl/csblk_serializer.sv
module csblk_serializer
    import csblk_pkg::*;
#(
    parameter int FRAMES = FRAMES_PER_BLOCK
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sf_valid,
    input  logic [1:0] sf_pre,
    input  logic       sf_c,
    input  logic       sf_u,
    input  logic       sf_v,
    input  logic       lrck,
    input  logic       vmode,
    output logic       blk_mark,
    output logic       unsynced,
    output logic       frame_err,
    output logic       c_ser,
    output logic       u_ser,
    output logic       v_ser
);

    pre_t      pre;
    aux_bits_t in_bits;
    aux_bits_t held_bits;
    aux_bits_t ser_bits;
    logic      synced;

    always_comb begin
        pre       = pre_t'(sf_pre);
        in_bits.c = sf_c;
        in_bits.u = sf_u;
        in_bits.v = sf_v;
    end

    csblk_framer #(.FRAMES(FRAMES)) u_framer (
        .clk    (clk),
        .rst    (rst),
        .strobe (sf_valid),
        .pre    (pre),
        .mark   (blk_mark),
        .synced (synced),
        .err    (frame_err)
    );

    csblk_shifter #(.NLANE(LANES)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .strobe  (sf_valid),
        .bits_in (in_bits),
        .lrck    (lrck),
        .held    (held_bits),
        .ser     (ser_bits)
    );

    always_comb begin
        unsynced = !synced;
        c_ser    = ser_bits.c;
        u_ser    = ser_bits.u;
        v_ser    = vmode ? held_bits.v : ser_bits.v;
    end

endmodule

// File: rtl/csblk_checker.sv
module csblk_checker (
    input logic       clk,
    input logic       rst,
    input logic       sf_valid,
    input logic [1:0] sf_pre,
    input logic       sf_v,
    input logic       lrck,
    input logic       vmode,
    input logic       blk_mark,
    input logic       unsynced,
    input logic       frame_err,
    input logic       c_ser,
    input logic       u_ser
);

    a_r2_no_mark_unsynced: assert property (@(posedge clk) disable iff (rst)
        unsynced |-> !blk_mark);

    a_r1_mark_from_z: assert property (@(posedge clk) disable iff (rst)
        $rose(blk_mark) |-> $past(sf_valid && sf_pre == 2'b00));

    a_r1_mark_drops: assert property (@(posedge clk) disable iff (rst)
        (sf_valid && sf_pre != 2'b00) |=> !blk_mark);

    a_r3_first_z_clean: assert property (@(posedge clk) disable iff (rst)
        (sf_valid && sf_pre == 2'b00 && unsynced) |=> !frame_err);

    a_r5_c_on_edge: assert property (@(posedge clk) disable iff (rst)
        !$stable(c_ser) |-> ($past(lrck) != $past(lrck, 2)));

    a_r5_u_on_edge: assert property (@(posedge clk) disable iff (rst)
        !$stable(u_ser) |-> ($past(lrck) != $past(lrck, 2)));

    a_r6_level_follows: assert property (@(posedge clk) disable iff (rst)
        (sf_valid && vmode) |=> (vmode -> (csblk_serializer.v_ser == $past(sf_v))));

    a_r7_reset_state: assert property (@(posedge clk)
        rst |=> (unsynced && !blk_mark && !frame_err && !c_ser && !u_ser));

endmodule

bind csblk_serializer csblk_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .sf_valid  (sf_valid),
    .sf_pre    (sf_pre),
    .sf_v      (sf_v),
    .lrck      (lrck),
    .vmode     (vmode),
    .blk_mark  (blk_mark),
    .unsynced  (unsynced),
    .frame_err (frame_err),
    .c_ser     (c_ser),
    .u_ser     (u_ser)
);

// File: tb/sim_csblk_serializer.sv
module sim_csblk_serializer;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] PZ = 2'b00;
    localparam logic [1:0] PX = 2'b01;
    localparam logic [1:0] PY = 2'b10;

    // each entry {v,u,c}; the serial outputs must show it after one word-clock edge
    localparam logic [2:0] VEC [8] = '{3'b000, 3'b111, 3'b001, 3'b010,
                                      3'b100, 3'b110, 3'b101, 3'b011};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sf_valid = 1'b0;
    logic [1:0] sf_pre = 2'b10;
    logic       sf_c = 1'b0, sf_u = 1'b0, sf_v = 1'b0;
    logic       lrck = 1'b0;
    logic       vmode = 1'b0;
    logic       blk_mark, unsynced, frame_err, c_ser, u_ser, v_ser;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csblk_serializer u0 (
        .clk(clk), .rst(rst), .sf_valid(sf_valid), .sf_pre(sf_pre),
        .sf_c(sf_c), .sf_u(sf_u), .sf_v(sf_v), .lrck(lrck), .vmode(vmode),
        .blk_mark(blk_mark), .unsynced(unsynced), .frame_err(frame_err),
        .c_ser(c_ser), .u_ser(u_ser), .v_ser(v_ser)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send(input logic [1:0] p, input logic [2:0] vuc);
        @(negedge clk);
        sf_valid = 1'b1; sf_pre = p;
        sf_v = vuc[2]; sf_u = vuc[1]; sf_c = vuc[0];
        @(negedge clk);
        sf_valid = 1'b0;
    endtask

    task automatic flip_lr();
        @(negedge clk);
        lrck = ~lrck;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();
        // R7 reset state
        chk("R7 unsynced", unsynced, 1'b1);
        chk("R7 blk_mark", blk_mark, 1'b0);
        chk("R7 frame_err", frame_err, 1'b0);
        chk("R7 c_ser", c_ser, 1'b0);
        chk("R7 u_ser", u_ser, 1'b0);
        chk("R7 v_ser", v_ser, 1'b0);

        // R4 table walk, alternating rising and falling word-clock edges
        for (int i = 0; i < 8; i++) begin
            send(PY, VEC[i]);
            flip_lr();
            chk("R4 c_ser", c_ser, VEC[i][0]);
            chk("R4 u_ser", u_ser, VEC[i][1]);
            chk("R4 v_ser", v_ser, VEC[i][2]);
        end

        // R5 no word-clock edge: outputs hold (last table value 3'b011)
        send(PY, 3'b100);
        repeat (3) @(negedge clk);
        chk("R5 c_ser hold", c_ser, 1'b1);
        chk("R5 u_ser hold", u_ser, 1'b1);
        chk("R5 v_ser hold", v_ser, 1'b0);
        flip_lr();
        chk("R5 c_ser after edge", c_ser, 1'b0);
        chk("R5 v_ser after edge", v_ser, 1'b1);

        // R6 level mode follows the latest V without any edge
        vmode = 1'b1;
        send(PY, 3'b000);
        chk("R6 level low", v_ser, 1'b0);
        send(PY, 3'b100);
        chk("R6 level high", v_ser, 1'b1);
        send(PX, 3'b000);
        chk("R6 level low again", v_ser, 1'b0);
        vmode = 1'b0;

        // R2 before sync
        do_reset();
        send(PX, 3'b000);
        chk("R2 no mark before sync", blk_mark, 1'b0);
        chk("R2 still unsynced", unsynced, 1'b1);
        send(PZ, 3'b000);
        chk("R2 first Z no mark", blk_mark, 1'b0);
        chk("R2 synced after first Z", unsynced, 1'b0);
        chk("R3 first Z no error", frame_err, 1'b0);
        send(PY, 3'b000);
        for (int f = 1; f < 192; f++) begin
            send(PX, 3'b000);
            send(PY, 3'b000);
        end
        send(PZ, 3'b000);
        chk("R1 mark on Z", blk_mark, 1'b1);
        chk("R3 on-time Z no error", frame_err, 1'b0);
        send(PY, 3'b000);
        chk("R1 mark drops after next strobe", blk_mark, 1'b0);

        // R3 short block
        for (int f = 1; f < 6; f++) begin
            send(PX, 3'b000);
            send(PY, 3'b000);
        end
        send(PZ, 3'b000);
        chk("R3 early Z sets error", frame_err, 1'b1);
        chk("R1 mark on early Z", blk_mark, 1'b1);
        send(PY, 3'b000);
        chk("R3 error held", frame_err, 1'b1);
        for (int f = 1; f < 192; f++) begin
            send(PX, 3'b000);
            send(PY, 3'b000);
        end
        send(PZ, 3'b000);
        chk("R3 on-time Z clears error", frame_err, 1'b0);

        // R7 reset after activity
        send(PZ, 3'b000);
        chk("R3 early Z again", frame_err, 1'b1);
        do_reset();
        chk("R7 error cleared", frame_err, 1'b0);
        chk("R7 unsynced again", unsynced, 1'b1);
        chk("R7 mark cleared", blk_mark, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule